// File: doc/BRIEF.md
# Memory Range Signature Engine

This block produces a 24-bit signature over a run of memory words so that software can confirm memory contents without reading every word itself. A single-cycle start pulse carries a word address. The engine then reads words one at a time through a simple read port with a fixed one-cycle latency. It folds each word into a multiple-input shift register that was preset to all ones. When the last word has been absorbed, it places the result in a held signature output and raises a one-cycle completion pulse.

The range depends on the start address. An address below the system threshold is rounded down to its page boundary, and signing runs upward from there. The last page of the block is left out. An address at or above the threshold instead selects the whole protected system region, whatever its exact value. If the rounded-down start page is already past the last signable page and the address is below the threshold, there is nothing to read, and the engine returns the seed value at once.

Top module: `mem_sig_gen`

## Requirements
- R1: While reset is held and after it is released, busy_o, done_o and mem_req_o are 0 and sig_o is 0 until the first completed run.
- R2: For a start address below SYS_BASE, the low log2(PAGE_WORDS) bits are cleared. The signed words run from that page start up to BLOCK_WORDS-PAGE_WORDS-1 inclusive, so the last page of the block is never read.
- R3: For a start address at or above SYS_BASE, the signed words are exactly SYS_BASE through SYS_BASE+SYS_WORDS-1.
- R4: The signature register is preset to all ones. For each word in ascending order it becomes step(reg XOR zero-extended word). In step(v), v is shifted left by one with a 0 entering bit 0, and the result is XORed with POLY when bit 23 of v was 1.
- R5: One read is made per word. Read addresses rise by exactly one on consecutive cycles, and mem_rdata_i is taken as the data for the address requested in the previous cycle.
- R6: done_o is high for exactly one cycle, in the same cycle that sig_o takes its new value. sig_o does not change in any other cycle.
- R7: For a range of N words, busy_o is high from the cycle after the start edge, and done_o appears with busy_o low in the cycle after the (N+1)th rising edge that follows the start edge.
- R8: A start pulse that arrives while busy_o is high is ignored and does not change the range or the result of the run in progress.
- R9: For a start address below SYS_BASE whose page start is above BLOCK_WORDS-PAGE_WORDS-1, no read is made, busy_o stays low, and done_o rises in the cycle after the start edge with sig_o equal to all ones.
- R10: busy_o is never high for BUDGET_CYCLES or more consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for a signature run |
| start_addr_i | input | ADDR_W | Word address that selects the range |
| mem_req_o | output | 1 | Read request for the memory |
| mem_addr_o | output | ADDR_W | Word address being read |
| mem_rdata_i | input | DATA_W | Read data, valid one cycle after the request |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse when the signature is written |
| sig_o | output | SIG_W | Last completed signature |

## Verification
On every cycle, the assertions check the following: reads are requested only while the engine is busy, and their addresses step up by one. No read ever touches the excluded last page. The completion pulse lasts one cycle and coincides with busy going low. The signature output holds between pulses, and the cycle budget is respected. Only the bench's scenarios can show that the range is selected correctly from a given start address (page rounding, system region, empty range), that the signature value matches the fold, that latency is N+1, and that a start arriving mid-run is ignored.

// File: rtl/mem_sig_gen.sv
module mem_sig_gen #(
  parameter int ADDR_W        = 12,
  parameter int DATA_W        = 16,
  parameter int SIG_W         = 24,
  parameter int PAGE_WORDS    = 16,
  parameter int BLOCK_WORDS   = 512,
  parameter int SYS_BASE      = 2048,
  parameter int SYS_WORDS     = 64,
  parameter int BUDGET_CYCLES = 6000,
  parameter logic [SIG_W-1:0] POLY = 24'h864CFB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [SIG_W-1:0]  sig_o
);
  localparam int PAGE_BITS = $clog2(PAGE_WORDS);
  localparam logic [ADDR_W-1:0] USER_LAST = ADDR_W'(BLOCK_WORDS - PAGE_WORDS - 1);
  localparam logic [ADDR_W-1:0] SYS_FIRST = ADDR_W'(SYS_BASE);
  localparam logic [ADDR_W-1:0] SYS_LAST  = ADDR_W'(SYS_BASE + SYS_WORDS - 1);
  localparam int CNT_W = $clog2(BUDGET_CYCLES + 1) + 1;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_DRAIN} state_t;

  state_t            st;
  logic [ADDR_W-1:0] cur_addr, last_addr;
  logic [SIG_W-1:0]  acc, sig_q;
  logic              pend, done_q;

  function automatic logic [SIG_W-1:0] lfsr_step(input logic [SIG_W-1:0] v);
    return {v[SIG_W-2:0], 1'b0} ^ (v[SIG_W-1] ? POLY : '0);
  endfunction

  wire               sys_sel    = start_addr_i >= SYS_FIRST;
  wire  [ADDR_W-1:0] page_start = {start_addr_i[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
  wire               empty_rng  = !sys_sel && (page_start > USER_LAST);
  wire  [SIG_W-1:0]  folded     = lfsr_step(acc ^ SIG_W'(mem_rdata_i));

  assign mem_req_o  = (st == S_READ);
  assign mem_addr_o = cur_addr;
  assign busy_o     = (st != S_IDLE);
  assign done_o     = done_q;
  assign sig_o      = sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cur_addr  <= '0;
      last_addr <= '0;
      acc       <= '1;
      sig_q     <= '0;
      pend      <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      pend   <= mem_req_o;
      case (st)
        S_IDLE: if (start_i) begin
          acc <= '1;
          if (empty_rng) begin
            sig_q  <= '1;
            done_q <= 1'b1;
          end else begin
            cur_addr  <= sys_sel ? SYS_FIRST : page_start;
            last_addr <= sys_sel ? SYS_LAST : USER_LAST;
            st        <= S_READ;
          end
        end
        S_READ: begin
          if (pend) acc <= folded;
          if (cur_addr == last_addr) st <= S_DRAIN;
          else cur_addr <= cur_addr + 1'b1;
        end
        S_DRAIN: begin
          sig_q  <= folded;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CNT_W-1:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy_o) busy_cnt <= '0;
    else if (busy_cnt != '1) busy_cnt <= busy_cnt + 1'b1;
  end

  // R5
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o);
  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && $past(mem_req_o) |-> mem_addr_o == $past(mem_addr_o) + 1'b1);
  // R2
  last_page_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_addr_o <= USER_LAST) || (mem_addr_o >= SYS_FIRST && mem_addr_o <= SYS_LAST));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R6
  sig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(sig_o));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R10
  budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> busy_cnt < CNT_W'(BUDGET_CYCLES));
endmodule

// File: tb/mem_sig_gen_bench.sv
`timescale 1ns/1ps
module mem_sig_gen_bench;
  localparam int AW = 12, DW = 16, SW = 24;
  localparam int PW = 16, BW = 512, SB = 2048, SN = 64;
  localparam logic [SW-1:0] POLY = 24'h864CFB;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic mem_req_o, busy_o, done_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_rdata_i = '0;
  logic [SW-1:0] sig_o;
  int checks = 0, failures = 0;
  int rd_cnt = 0;
  int rd_first = -1, rd_last = -1, rd_gap = 0;

  always #10 clk = ~clk;

  mem_sig_gen u_mem_sig_gen (.clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .sig_o(sig_o));

  function automatic logic [DW-1:0] mem_word(input int a);
    return DW'(a * 40503) ^ 16'h5A5A;
  endfunction

  always @(posedge clk) begin
    mem_rdata_i <= mem_word(int'(mem_addr_o));
    if (mem_req_o) begin
      if (rd_cnt == 0) rd_first = int'(mem_addr_o);
      else if (int'(mem_addr_o) != rd_last + 1) rd_gap++;
      rd_last = int'(mem_addr_o);
      rd_cnt++;
    end
  end

  function automatic logic [SW-1:0] ref_sig(input int lo, input int hi);
    logic [SW-1:0] r = '1;
    for (int a = lo; a <= hi; a++) begin
      logic fb;
      r = r ^ {8'h00, mem_word(a)};
      fb = r[SW-1];
      r = r << 1;
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "busy in reset", busy_o, 0);
    check("R1", "req in reset", mem_req_o, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "done after reset", done_o, 0);
    check("R1", "sig after reset", sig_o, 0);
    check("R1", "busy after reset", busy_o, 0);
  endtask

  // Runs one signature and checks range, value, latency; mid_addr>=0 injects a start while busy.
  task automatic t_run(input string req, input int addr, input int mid_addr);
    int lo, hi, n, cnt, busy_bad;
    bit empty;
    if (addr >= SB) begin lo = SB; hi = SB + SN - 1; end
    else begin lo = addr & ~(PW - 1); hi = BW - PW - 1; end
    empty = lo > hi;
    n = empty ? 0 : hi - lo + 1;
    rd_cnt = 0; rd_gap = 0; rd_first = -1; rd_last = -1;
    start_addr_i = AW'(addr);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cnt = 0; busy_bad = 0;
    while (cnt < 5000) begin
      if (cnt > 0) @(negedge clk);
      cnt++;
      if (done_o) break;
      if (!busy_o) busy_bad++;
      if (mid_addr >= 0 && cnt == 3) begin
        start_addr_i = AW'(mid_addr);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cnt++;
        if (done_o) break;
      end
    end
    check(req, "done seen", done_o, 1);
    check("R7", "latency", cnt, empty ? 1 : n + 2);
    check("R7", "busy during run", busy_bad, 0);
    check("R7", "busy low at done", busy_o, 0);
    check("R4", "signature", sig_o, ref_sig(lo, hi));
    check("R5", "read count", rd_cnt, n);
    check("R5", "read gaps", rd_gap, 0);
    if (!empty) begin
      check(req, "first address", rd_first, lo);
      check(req, "last address", rd_last, hi);
    end
    @(negedge clk);
    check("R6", "done one cycle", done_o, 0);
    check("R6", "sig held", sig_o, ref_sig(lo, hi));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_run("R2", 0, -1);
    t_run("R2", 'h1A5, -1);
    t_run("R2", BW - 2 * PW + 7, -1);
    t_run("R3", SB, -1);
    t_run("R3", 'hFFF, -1);
    t_run("R9", BW - PW + 3, -1);
    t_run("R9", 'h600, -1);
    t_run("R8", 'h1C0, SB);
    t_run("R10", 0, -1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule